// File: doc/BRIEF.md
# Receive-Level RTS Flow Controller

This block drives the active-low request-to-send pin of a serial receiver from the fill level of its receive FIFO. With automatic flow control switched on, the pin goes high when the FIFO fills past a threshold. The pin stays high while the FIFO drains through a band of levels. It returns low only when the fill falls below a lower threshold. Both thresholds come from a ladder of four trigger levels. The upper threshold is the rung above the programmed trigger level, and the lower threshold is the rung below it. Because the gap between them is wide, the link partner is not stopped and restarted on every byte.

The same programmed trigger level also drives a receive interrupt, which tells the host to come and empty the FIFO. With automatic flow control switched off, the pin simply follows a software-written RTS bit. The FIFO and the registers that hold the controls are outside this block. It sees only the fill count and the control values.

Top module: `uart_auto_rts`

## Requirements
- R1: The 2-bit trigger select picks the interrupt trigger level: code 0 is 1 byte, code 1 is 4 bytes, code 2 is 8 bytes, code 3 is 14 bytes (FIFO depth 16).
- R2: `rx_irq_o` is 1 in the cycle after a clock edge at which the fill count is at or above the selected trigger level.
- R3: `rx_irq_o` is 0 in the cycle after a clock edge at which the fill count is below the selected trigger level.
- R4: With `auto_rts_en_i`=1, `rts_no` is 1 in the cycle after an edge at which the fill is at or above the next rung up. The next rung up is 4, 8, 14, and 16 (FIFO full) for codes 0 to 3.
- R5: With `auto_rts_en_i`=1, `rts_no` is 0 in the cycle after an edge at which the fill is below the next rung down. The next rung down is 0 for code 0, so the pin reasserts only at an empty FIFO; it is 1, 4, 8 for codes 1 to 3.
- R6: With `auto_rts_en_i`=1 and the fill between the two rungs, `rts_no` keeps its previous value. This holds on the first enabled cycle too.
- R7: With `auto_rts_en_i`=0, `rts_no` equals the inverse of `rts_manual_i` sampled at the previous edge (manual bit 1 drives the pin low).
- R8: While `rst_ni` is low, `rts_no` is 1 and `rx_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_count_i | input | 5 | Receive FIFO fill count, 0 to 16 |
| trig_sel_i | input | 2 | Trigger level select code |
| auto_rts_en_i | input | 1 | Automatic RTS flow control enable |
| rts_manual_i | input | 1 | Software RTS bit, 1 = request to send |
| rts_no | output | 1 | RTS pin, active low |
| rx_irq_o | output | 1 | Receive trigger-level interrupt |

## Verification
The properties assume that the fill count never exceeds the FIFO depth. They also assume that the inputs change only between clock edges, so each one-cycle implication compares the registered outputs with the inputs seen at the edge before. The stimulus drives every input on the falling clock edge and keeps every count in the range 0 to 16. The sequence starts with the pin in both states, then walks each trigger code through the band between its rungs, across both rung edges, and through the enable switching on and off.

// File: rtl/uart_rts_pkg.sv
package uart_rts_pkg;
  typedef enum logic [1:0] {
    TRIG_L0 = 2'd0,
    TRIG_L1 = 2'd1,
    TRIG_L2 = 2'd2,
    TRIG_L3 = 2'd3
  } trig_sel_e;

  localparam int NUM_LVL = 4;
endpackage

// File: rtl/rts_thr_decode.sv
module rts_thr_decode
  import uart_rts_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  trig_sel_e          sel_i,
  output logic [CNT_W-1:0]   trig_o,
  output logic [CNT_W-1:0]   up_o,
  output logic [CNT_W-1:0]   dn_o
);
  localparam int LVL [NUM_LVL] = '{LVL0, LVL1, LVL2, LVL3};

  logic [CNT_W-1:0] trig_tab [NUM_LVL];
  logic [CNT_W-1:0] up_tab   [NUM_LVL];
  logic [CNT_W-1:0] dn_tab   [NUM_LVL];

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    assign trig_tab[i] = CNT_W'(LVL[i]);
    if (i == NUM_LVL - 1) begin : g_top
      assign up_tab[i] = CNT_W'(DEPTH);
    end else begin : g_mid_up
      assign up_tab[i] = CNT_W'(LVL[i+1]);
    end
    // lowest rung: "below" the floor means an empty FIFO
    if (i == 0) begin : g_bot
      assign dn_tab[i] = CNT_W'(1);
    end else begin : g_mid_dn
      assign dn_tab[i] = CNT_W'(LVL[i-1]);
    end
  end

  assign trig_o = trig_tab[sel_i];
  assign up_o   = up_tab[sel_i];
  assign dn_o   = dn_tab[sel_i];
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             manual_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] up_i,
  input  logic [CNT_W-1:0] dn_i,
  output logic             rts_no
);
  logic rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rts_q <= 1'b1;
    else if (!en_i)          rts_q <= ~manual_i;
    else if (cnt_i >= up_i)  rts_q <= 1'b1;
    else if (cnt_i <  dn_i)  rts_q <= 1'b0;
  end

  assign rts_no = rts_q;
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] trig_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (cnt_i >= trig_i);
  end
endmodule

// File: rtl/uart_auto_rts.sv
module uart_auto_rts
  import uart_rts_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             auto_rts_en_i,
  input  logic             rts_manual_i,
  output logic             rts_no,
  output logic             rx_irq_o
);
  logic [CNT_W-1:0] trig_lvl, up_lvl, dn_lvl;

  rts_thr_decode #(
    .DEPTH(DEPTH), .CNT_W(CNT_W),
    .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_dec (
    .sel_i  (trig_sel_e'(trig_sel_i)),
    .trig_o (trig_lvl),
    .up_o   (up_lvl),
    .dn_o   (dn_lvl)
  );

  rts_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (auto_rts_en_i),
    .manual_i (rts_manual_i),
    .cnt_i    (rx_count_i),
    .up_i     (up_lvl),
    .dn_i     (dn_lvl),
    .rts_no   (rts_no)
  );

  rx_irq_gen #(.CNT_W(CNT_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (rx_count_i),
    .trig_i (trig_lvl),
    .irq_o  (rx_irq_o)
  );
endmodule

// File: rtl/uart_auto_rts_chk.sv
module uart_auto_rts_chk #(
  parameter int DEPTH = 16,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [1:0]       trig_sel_i,
  input logic             auto_rts_en_i,
  input logic             rts_manual_i,
  input logic             rts_no,
  input logic             rx_irq_o
);
  int trig_e, hi_e, lo_e, cnt_e;

  always_comb begin
    cnt_e = int'(rx_count_i);
    case (trig_sel_i)
      2'd0:    begin trig_e = LVL0; hi_e = LVL1;  lo_e = 0;    end
      2'd1:    begin trig_e = LVL1; hi_e = LVL2;  lo_e = LVL0; end
      2'd2:    begin trig_e = LVL2; hi_e = LVL3;  lo_e = LVL1; end
      default: begin trig_e = LVL3; hi_e = DEPTH; lo_e = LVL2; end
    endcase
  end

  // lowest rung reasserts only at empty
  logic below_lo, above_hi;
  assign below_lo = (trig_sel_i == 2'd0) ? (cnt_e == 0) : (cnt_e < lo_e);
  assign above_hi = cnt_e >= hi_e;

  // R2
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_e >= trig_e) |=> rx_irq_o);

  // R3
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_e < trig_e) |=> !rx_irq_o);

  // R4
  rts_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && above_hi) |=> rts_no);

  // R5
  rts_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && below_lo) |=> !rts_no);

  // R6
  rts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_rts_en_i && !below_lo && !above_hi) |=> $stable(rts_no));

  // R7
  rts_manual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> (rts_no == !$past(rts_manual_i)));

  // count never past depth is an input assumption
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_e <= DEPTH);
endmodule

bind uart_auto_rts uart_auto_rts_chk #(
  .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_count_i    (rx_count_i),
  .trig_sel_i    (trig_sel_i),
  .auto_rts_en_i (auto_rts_en_i),
  .rts_manual_i  (rts_manual_i),
  .rts_no        (rts_no),
  .rx_irq_o      (rx_irq_o)
);

// File: tb/sim_uart_auto_rts.sv
module sim_uart_auto_rts;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] rx_count_i = '0;
  logic [1:0] trig_sel_i = '0;
  logic       auto_rts_en_i = 1'b0;
  logic       rts_manual_i = 1'b0;
  logic       rts_no, rx_irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_auto_rts u0 (.*);

  typedef struct packed {
    logic [1:0] sel;
    logic       en;
    logic       man;
    logic [4:0] cnt;
    logic       rts;
    logic       irq;
    logic [3:0] req;  // requirement exercised by the rts check
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 4'd7}, // R7 manual on
    '{2'd1, 1'b0, 1'b0, 5'd5,  1'b1, 1'b1, 4'd7}, // R7 manual off
    '{2'd1, 1'b1, 1'b0, 5'd3,  1'b1, 1'b0, 4'd6}, // R6 hold on enable
    '{2'd1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 4'd5}, // R5
    '{2'd1, 1'b1, 1'b0, 5'd4,  1'b0, 1'b1, 4'd6},
    '{2'd1, 1'b1, 1'b0, 5'd7,  1'b0, 1'b1, 4'd6},
    '{2'd1, 1'b1, 1'b0, 5'd8,  1'b1, 1'b1, 4'd4}, // R4
    '{2'd1, 1'b1, 1'b0, 5'd2,  1'b1, 1'b0, 4'd6},
    '{2'd1, 1'b1, 1'b0, 5'd1,  1'b1, 1'b0, 4'd6}, // at lower rung: hold
    '{2'd1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 4'd5},
    '{2'd3, 1'b1, 1'b0, 5'd15, 1'b0, 1'b1, 4'd6},
    '{2'd3, 1'b1, 1'b0, 5'd16, 1'b1, 1'b1, 4'd4}, // R4 full
    '{2'd3, 1'b1, 1'b0, 5'd8,  1'b1, 1'b0, 4'd6},
    '{2'd3, 1'b1, 1'b0, 5'd7,  1'b0, 1'b0, 4'd5},
    '{2'd0, 1'b1, 1'b0, 5'd3,  1'b0, 1'b1, 4'd6},
    '{2'd0, 1'b1, 1'b0, 5'd4,  1'b1, 1'b1, 4'd4},
    '{2'd0, 1'b1, 1'b0, 5'd1,  1'b1, 1'b1, 4'd6}, // R5 no release above empty
    '{2'd0, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 4'd5},
    '{2'd2, 1'b1, 1'b0, 5'd14, 1'b1, 1'b1, 4'd4},
    '{2'd2, 1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 4'd6},
    '{2'd2, 1'b1, 1'b0, 5'd3,  1'b0, 1'b0, 4'd5},
    '{2'd2, 1'b1, 1'b0, 5'd7,  1'b0, 1'b0, 4'd6},
    '{2'd2, 1'b1, 1'b0, 5'd8,  1'b0, 1'b1, 4'd6},
    '{2'd2, 1'b0, 1'b1, 5'd8,  1'b0, 1'b1, 4'd7},
    '{2'd2, 1'b0, 1'b0, 5'd8,  1'b1, 1'b1, 4'd7},
    '{2'd2, 1'b1, 1'b0, 5'd10, 1'b1, 1'b1, 4'd6}
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic e, input logic m, input logic [4:0] c);
    @(negedge clk_i);
    trig_sel_i = s; auto_rts_en_i = e; rts_manual_i = m; rx_count_i = c;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  localparam int LADDER [4] = '{1, 4, 8, 14};

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk_i);
    check("R8", rts_no, 1'b1, "rts in reset");
    check("R8", rx_irq_o, 1'b0, "irq in reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].sel, VEC[i].en, VEC[i].man, VEC[i].cnt);
      check($sformatf("R%0d", VEC[i].req), rts_no, VEC[i].rts, $sformatf("vec %0d rts", i));
      check(VEC[i].irq ? "R2" : "R3", rx_irq_o, VEC[i].irq, $sformatf("vec %0d irq", i));
    end

    // R1 each code: one below the level, then at it
    for (int s = 0; s < 4; s++) begin
      step(2'(s), 1'b0, 1'b0, 5'(LADDER[s] - 1));
      check("R1", rx_irq_o, 1'b0, $sformatf("code %0d below level", s));
      step(2'(s), 1'b0, 1'b0, 5'(LADDER[s]));
      check("R1", rx_irq_o, 1'b1, $sformatf("code %0d at level", s));
    end

    // R8 mid-run reset from pin low, irq high
    step(2'd0, 1'b0, 1'b1, 5'd5);
    check("R7", rts_no, 1'b0, "pin low before reset");
    #2 rst_ni = 1'b0;
    #1;
    check("R8", rts_no, 1'b1, "rts after async reset");
    check("R8", rx_irq_o, 1'b0, "irq after async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule